// File: doc/BRIEF.md
# I2C Master Bus Timeout Monitor

This block sits beside the clock generator and shifter of an I2C master and decides when the bus has been stuck long enough to count as a bus error. It counts bit-period ticks from an external prescaler. The limit is an 8-bit setting: the timeout is (setting + 1) bit periods, and a setting of zero turns the monitor off.

The timer arms in three situations. The first is a pending START request that cannot yet be issued. The second is a pending STOP request that has not yet been seen on the bus. The third is SCL being held low. A START or STOP request that arrives while a byte is on the wire does not arm the timer until the byte-active indication drops, which marks the end of the low time of the acknowledge bit. On expiry the block sets a sticky flag, drives an interrupt if it is enabled, gives a one-cycle abort pulse if a transfer was busy, and clears the busy status. The bus-occupied status is kept until a STOP is detected or the controller is disabled.

The state machine has five states. WD_IDLE is the unarmed state. WD_DEFER waits for the in-flight byte to end. WD_REQ times a pending START or STOP. WD_SCL times a low SCL. WD_HOLD is entered after expiry and waits for the stuck condition to clear. The transitions are:
- WD_IDLE to WD_DEFER on a request while a byte is active.
- WD_IDLE to WD_REQ on a request with no byte active.
- WD_IDLE to WD_SCL on SCL low with no request.
- WD_DEFER to WD_REQ when the byte ends.
- WD_DEFER to WD_IDLE when the request is withdrawn.
- WD_REQ to WD_IDLE when a START is issued, a STOP is seen, or the request is withdrawn.
- WD_SCL to WD_IDLE when SCL goes high.
- WD_REQ or WD_SCL to WD_HOLD on expiry.
- WD_HOLD to WD_IDLE once SCL is high and no request is pending.
- Any state to WD_IDLE when the monitor is disabled or the limit is zero.

Top module: `i2c_bus_watchdog`

## Requirements
- R1: With limit L (1..255), the flag sets on the clock edge that samples the (L+1)th bit tick counted while armed, and stays 0 after only L such ticks.
- R2: A limit of 0 disables the monitor, so no number of ticks sets the flag.
- R3: SCL low arms the timer. SCL high before expiry returns the monitor to idle without a flag, and the next low period counts from zero.
- R4: A pending START request (start_req high, no byte active) arms the timer. A start_issued pulse before expiry ends it without a flag and sets busy and bus_occ.
- R5: A pending STOP request arms the timer. A stop_seen pulse before expiry ends it without a flag and clears busy and bus_occ.
- R6: A request made while byte_active is 1 counts no ticks until byte_active returns to 0. Timing then starts from zero.
- R7: The flag is sticky and is cleared only by a flag_clr pulse. A set in the same cycle as a clear wins.
- R8: irq is 1 exactly when the flag is 1 and irq_en is 1.
- R9: On expiry while busy is 1, abort is high for exactly one cycle and busy goes to 0 on the same edge.
- R10: bus_occ stays 1 after a timeout until stop_seen or enable low.
- R11: enable low clears busy and bus_occ on the next edge and returns the monitor to idle.
- R12: After expiry the monitor does not count again until SCL is high and no request is pending, so further ticks cannot set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| to_limit | input | W | Timeout setting, 0 disables |
| start_req | input | 1 | START requested (level) |
| stop_req | input | 1 | STOP requested (level) |
| byte_active | input | 1 | A byte is in flight until the ACK low time ends |
| scl_in | input | 1 | Synchronized SCL |
| start_issued | input | 1 | Pulse: START generated on the bus |
| stop_seen | input | 1 | Pulse: STOP condition detected |
| irq_en | input | 1 | Interrupt enable for the flag |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| to_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |
| abort | output | 1 | One-cycle abort of the transfer in progress |
| busy | output | 1 | Transfer busy status |
| bus_occ | output | 1 | Bus-occupied status |

## Verification
The bench sweeps the limit across small values and 255, and counts ticks exactly up to L and L+1. A counter that is off by one flags one tick early or one tick late. A request raised while a byte is active is given more than L+1 ticks before the byte ends. A monitor that fails to defer would flag during the byte. The bench also checks that a START, STOP or SCL-high arriving at L ticks ends the timing cleanly, that bus_occ survives the abort while busy drops, and that a clear issued in the hold state is not undone by further ticks on a still-stuck bus. A design that re-armed from the hold state would raise the flag again.

// File: rtl/i2c_wd_pkg.sv
package i2c_wd_pkg;
    typedef enum logic [2:0] {
        WD_IDLE  = 3'd0,
        WD_DEFER = 3'd1,
        WD_REQ   = 3'd2,
        WD_SCL   = 3'd3,
        WD_HOLD  = 3'd4
    } wd_state_t;
endpackage

// File: rtl/i2c_wd_timer.sv
module i2c_wd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    // Count bit ticks while armed; drop to zero whenever not armed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // The (limit+1)th tick arrives when cnt_q already equals limit.
    assign hit = run && tick && (cnt_q == limit);
endmodule

// File: rtl/i2c_wd_status.sv
module i2c_wd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trip,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic start_issued,
    input  logic stop_seen,
    output logic to_flag,
    output logic irq,
    output logic abort,
    output logic busy,
    output logic bus_occ
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
            abort   <= 1'b0;
            busy    <= 1'b0;
            bus_occ <= 1'b0;
        end else begin
            // A set in the same cycle as a clear wins.
            if (trip)
                to_flag <= 1'b1;
            else if (flag_clr)
                to_flag <= 1'b0;

            abort <= trip && busy;

            if (!enable || trip || stop_seen)
                busy <= 1'b0;
            else if (start_issued)
                busy <= 1'b1;

            if (!enable || stop_seen)
                bus_occ <= 1'b0;
            else if (start_issued)
                bus_occ <= 1'b1;
        end
    end

    assign irq = to_flag && irq_en;
endmodule

// File: rtl/i2c_bus_watchdog.sv
module i2c_bus_watchdog
    import i2c_wd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         bit_tick,
    input  logic [W-1:0] to_limit,
    input  logic         start_req,
    input  logic         stop_req,
    input  logic         byte_active,
    input  logic         scl_in,
    input  logic         start_issued,
    input  logic         stop_seen,
    input  logic         irq_en,
    input  logic         flag_clr,
    output logic         to_flag,
    output logic         irq,
    output logic         abort,
    output logic         busy,
    output logic         bus_occ
);
    wd_state_t st_q, st_d;
    logic off, req, req_done, armed, hit, trip;

    assign off      = !enable || (to_limit == '0);
    assign req      = start_req || stop_req;
    assign req_done = start_issued || stop_seen || !req;
    assign armed    = (st_q == WD_REQ) || (st_q == WD_SCL);

    i2c_wd_timer #(.W(W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (armed && !off),
        .tick  (bit_tick),
        .limit (to_limit),
        .hit   (hit)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= WD_IDLE;
        else
            st_q <= st_d;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_IDLE: begin
                if (off)
                    st_d = WD_IDLE;
                else if (req)
                    st_d = byte_active ? WD_DEFER : WD_REQ;
                else if (!scl_in)
                    st_d = WD_SCL;
            end
            WD_DEFER: begin
                if (off || !req)
                    st_d = WD_IDLE;
                else if (!byte_active)
                    st_d = WD_REQ;
            end
            WD_REQ: begin
                if (off || req_done)
                    st_d = WD_IDLE;
                else if (hit)
                    st_d = WD_HOLD;
            end
            WD_SCL: begin
                if (off || scl_in)
                    st_d = WD_IDLE;
                else if (hit)
                    st_d = WD_HOLD;
            end
            WD_HOLD: begin
                if (off || (scl_in && !req))
                    st_d = WD_IDLE;
            end
            default: st_d = WD_IDLE;
        endcase
    end

    // Expiry is the move into the hold state.
    assign trip = (st_d == WD_HOLD) && (st_q != WD_HOLD);

    i2c_wd_status status_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .trip         (trip),
        .flag_clr     (flag_clr),
        .irq_en       (irq_en),
        .start_issued (start_issued),
        .stop_seen    (stop_seen),
        .to_flag      (to_flag),
        .irq          (irq),
        .abort        (abort),
        .busy         (busy),
        .bus_occ      (bus_occ)
    );
endmodule

// File: rtl/i2c_bus_watchdog_chk.sv
module i2c_bus_watchdog_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic [W-1:0] to_limit,
    input logic         irq_en,
    input logic         flag_clr,
    input logic         to_flag,
    input logic         irq,
    input logic         abort,
    input logic         busy,
    input logic         bus_occ
);
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (to_flag && irq_en));

    assert_abort_drops_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !busy);

    assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    assert_zero_limit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> ($past(to_limit) != '0));

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !bus_occ));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !flag_clr) |=> to_flag);

    assert_busy_inside_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bus_occ);
endmodule

bind i2c_bus_watchdog i2c_bus_watchdog_chk #(.W(W)) chk_i (.*);

// File: tb/i2c_bus_watchdog_tb.sv
module i2c_bus_watchdog_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, bit_tick = 1'b0;
    logic [7:0] to_limit = 8'd0;
    logic       start_req = 1'b0, stop_req = 1'b0, byte_active = 1'b0;
    logic       scl_in = 1'b1, start_issued = 1'b0, stop_seen = 1'b0;
    logic       irq_en = 1'b0, flag_clr = 1'b0;
    logic       to_flag, irq, abort, busy, bus_occ;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    i2c_bus_watchdog #(.W(8)) dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            bit_tick = 1'b1; @(negedge clk);
            bit_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; @(negedge clk);
        flag_clr = 1'b0; @(negedge clk);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lims[7] = '{1, 2, 3, 4, 5, 6, 255};
        cyc(2);
        check("R7 reset flag", to_flag, 0);
        check("R11 reset busy", busy, 0);
        check("R11 reset bus", bus_occ, 0);
        rst_n = 1'b1; enable = 1'b1;
        cyc(2);

        // R1 sweep with the SCL-low trigger
        foreach (lims[k]) begin
            int l = lims[k];
            to_limit = l[7:0];
            scl_in = 1'b0; cyc(1);
            ticks(l);
            check($sformatf("R1 L=%0d after L ticks", l), to_flag, 0);
            ticks(1);
            check($sformatf("R1 L=%0d after L+1 ticks", l), to_flag, 1);
            scl_in = 1'b1; cyc(2);
            clr_flag();
            check("R7 clear pulse", to_flag, 0);
        end

        // R3 restart on SCL high
        to_limit = 8'd3;
        scl_in = 1'b0; cyc(1); ticks(3);
        scl_in = 1'b1; cyc(2);
        scl_in = 1'b0; cyc(1); ticks(3);
        check("R3 restart from zero", to_flag, 0);
        ticks(1);
        check("R3 low period expiry", to_flag, 1);

        // R12 hold: clear while SCL still low, more ticks
        clr_flag();
        ticks(6);
        check("R12 no re-trigger in hold", to_flag, 0);
        scl_in = 1'b1; cyc(2);

        // R7 sticky and set beats clear
        scl_in = 1'b0; cyc(1); ticks(4);
        scl_in = 1'b1; cyc(3);
        check("R7 sticky after bus recovers", to_flag, 1);
        scl_in = 1'b0; cyc(1); ticks(3);
        bit_tick = 1'b1; flag_clr = 1'b1; @(negedge clk);
        bit_tick = 1'b0; flag_clr = 1'b0; @(negedge clk);
        check("R7 set wins over clear", to_flag, 1);

        // R8 interrupt gating
        check("R8 irq off when disabled", irq, 0);
        irq_en = 1'b1; #1;
        check("R8 irq on", irq, 1);
        scl_in = 1'b1; cyc(2); clr_flag();
        check("R8 irq follows clear", irq, 0);

        // R2 zero limit
        to_limit = 8'd0;
        scl_in = 1'b0; cyc(1); ticks(20);
        check("R2 zero limit", to_flag, 0);
        scl_in = 1'b1; cyc(2);

        // R4 START issued in time
        to_limit = 8'd2;
        start_req = 1'b1; cyc(1); ticks(2);
        start_req = 1'b0; start_issued = 1'b1; @(negedge clk);
        start_issued = 1'b0; cyc(1); ticks(5);
        check("R4 start in time no flag", to_flag, 0);
        check("R4 busy set", busy, 1);
        check("R4 bus set", bus_occ, 1);

        // R5 STOP seen in time
        stop_req = 1'b1; cyc(1); ticks(2);
        stop_req = 1'b0; stop_seen = 1'b1; @(negedge clk);
        stop_seen = 1'b0; cyc(1); ticks(5);
        check("R5 stop in time no flag", to_flag, 0);
        check("R5 busy cleared", busy, 0);
        check("R5 bus cleared", bus_occ, 0);

        // R5 STOP never seen -> timeout
        stop_req = 1'b1; cyc(1); ticks(3);
        check("R5 stop timeout", to_flag, 1);
        stop_req = 1'b0; cyc(2); clr_flag();

        // R6 deferral during a byte
        start_issued = 1'b1; @(negedge clk); start_issued = 1'b0;
        byte_active = 1'b1; start_req = 1'b1; cyc(1);
        ticks(6);
        check("R6 no count during byte", to_flag, 0);
        byte_active = 1'b0; cyc(1);
        ticks(2);
        check("R6 counts from byte end", to_flag, 0);

        // R9 abort pulse on expiry while busy
        bit_tick = 1'b1; @(negedge clk);
        check("R6 expiry after byte", to_flag, 1);
        check("R9 abort pulse", abort, 1);
        check("R9 busy cleared", busy, 0);
        check("R10 bus held", bus_occ, 1);
        bit_tick = 1'b0; @(negedge clk);
        check("R9 abort one cycle", abort, 0);
        start_req = 1'b0; cyc(3);
        check("R10 bus still held", bus_occ, 1);
        stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0; @(negedge clk);
        check("R10 bus freed by stop", bus_occ, 0);
        clr_flag();

        // R9 no abort when not busy
        scl_in = 1'b0; cyc(1); ticks(2);
        bit_tick = 1'b1; @(negedge clk);
        check("R9 no abort when idle", abort, 0);
        bit_tick = 1'b0; scl_in = 1'b1; cyc(2); clr_flag();

        // R10 / R11 enable low
        start_issued = 1'b1; @(negedge clk); start_issued = 1'b0; cyc(1);
        enable = 1'b0; cyc(1);
        check("R11 disable clears busy", busy, 0);
        check("R10 disable frees bus", bus_occ, 0);
        scl_in = 1'b0; ticks(8);
        check("R11 disabled no flag", to_flag, 0);
        scl_in = 1'b1; enable = 1'b1; cyc(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule